// File: doc/BRIEF.md
# Differential PSK Barker Spreader

This block turns a serial stream of already-scrambled data bits into chip-rate in-phase and quadrature output bits for the two low-rate modes of a direct-sequence transmitter. In the binary mode each input bit moves a differential phase state by 0° or 180°, and both output channels carry the same value. In the quaternary mode bits are taken two at a time, and each pair moves the phase by a quarter-turn step. The two bits of the resulting phase state drive the two channels separately.

Each symbol is then spread by an 11-chip Barker word. One chip goes out for every strobe on the chip-enable input, so a symbol lasts exactly eleven strobes. The current phase state is presented at an output port. A following high-rate stage can use it as its phase reference once the last header symbol has gone out. If no complete symbol is waiting when a symbol period ends, the block emits zero chips and flags the gap.

Top module: `dpsk_barker_spreader`

## Requirements
- R1: After reset the phase state is 00 (0°), both chip outputs are 0, underrun is 0 and bitReady is 1.
- R2: bitReady stays high until one bit (binary mode) or two bits (quaternary mode) have been accepted. It then stays low until that symbol is loaded at a symbol-boundary strobe, and goes high again in the cycle after the load.
- R3: In binary mode (modeQuad=0) an input 1 advances the phase by 180° and an input 0 leaves it unchanged. Both chip outputs carry phase bit 1 XOR the Barker chip, so chipI equals chipQ.
- R4: In quaternary mode the first bit in time is D0 and the second is D1. The pair D0D1 advances the phase by 0° for 00, +90° for 01, +180° for 11 and −90° for 10. The phase quadrant is coded 00=0°, 01=90°, 11=180°, 10=270°, with bit 1 feeding I and bit 0 feeding Q.
- R5: With rotReverse=1 the +90° and −90° steps of R4 swap, while the 0° and 180° steps are unchanged.
- R6: In quaternary mode chipI carries phase bit 1 and chipQ carries phase bit 0, each XORed with the current Barker chip.
- R7: The Barker chips are 1,0,1,1,0,1,1,1,0,0,0, with the first listed chip sent first. Each chip-enable strobe produces the next chip on the outputs in the following clock cycle, and the outputs hold between strobes.
- R8: A loaded symbol occupies exactly 11 strobes. The next symbol is loaded on the 12th strobe.
- R9: Suppose a symbol stream is running and a symbol-boundary strobe finds no complete symbol. Then both chip outputs go to 0, underrun is high for exactly one cycle, and the stream stops. A boundary strobe while stopped with no symbol also gives zero chips, but raises no underrun.
- R10: phaseRef shows the phase after the most recently loaded symbol. It holds through idle periods and underruns, and the differential chain continues across a change of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeQuad | input | 1 | 0 = one bit per symbol, 1 = two bits per symbol; change only while stopped |
| rotReverse | input | 1 | Reverses the rotation sense of the quarter-turn steps |
| chipEn | input | 1 | Chip-rate strobe, one chip per high cycle |
| bitValid | input | 1 | Input bit offered |
| bitData | input | 1 | Input bit value |
| bitReady | output | 1 | Block can take a bit this cycle |
| chipI | output | 1 | Registered in-phase chip |
| chipQ | output | 1 | Registered quadrature chip |
| underrun | output | 1 | One-cycle pulse when a running stream misses a symbol |
| phaseRef | output | 2 | Current differential phase quadrant |

## Verification
The quaternary mode is driven with a directed dibit sequence that walks through all four pairs in turn, once in each rotation sense. The 90° and 270° steps differ only in sign, so this separates a correct map from one with swapped rotation or with D0 and D1 reversed. A directed binary run alternates pairs of zeros and ones, which shows that 0 holds the phase and 1 inverts it. The run starts from a quaternary phase, so the chain is also checked across a mode change. Random runs with random mode, rotation and stream length then check every chip of every symbol against the Barker pattern. Each run ends with a missing symbol, which exercises the zero-output underrun path and the phase hold that follows.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;

  typedef struct packed {
    logic shiftIn;
    logic loadSym;
    logic emitChip;
    logic zeroOut;
    logic underrun;
  } spreadStrb_t;

  function automatic logic [1:0] quadToIdx(input logic [1:0] quad);
    return {quad[1], quad[1] ^ quad[0]};
  endfunction

  function automatic logic [1:0] idxToQuad(input logic [1:0] idx);
    return {idx[1], idx[1] ^ idx[0]};
  endfunction

endpackage

// File: rtl/dpsk_phase_step.sv
module dpsk_phase_step (
  input  logic [1:0] curPhase,
  input  logic       modeQuad,
  input  logic       rotReverse,
  input  logic [1:0] pendBits,
  output logic [1:0] nxtPhase
);
  import dpsk_pkg::*;

  logic [1:0] stepIdx;
  logic [1:0] sumIdx;

  always_comb begin
    if (modeQuad) begin
      stepIdx = {pendBits[1], pendBits[1] ^ pendBits[0]};
      if (rotReverse && stepIdx[0]) stepIdx = stepIdx ^ 2'b10;
    end else begin
      stepIdx = {pendBits[0], 1'b0};
    end
    sumIdx   = quadToIdx(curPhase) + stepIdx;
    nxtPhase = idxToQuad(sumIdx);
  end

endmodule

// File: rtl/dpsk_spread_ctrl.sv
module dpsk_spread_ctrl #(
  parameter int CHIPS = 11,
  localparam int IDX_W = $clog2(CHIPS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    modeQuad,
  input  logic                    chipEn,
  input  logic                    bitValid,
  output logic                    bitReady,
  output logic [IDX_W-1:0]        chipIdx,
  output dpsk_pkg::spreadStrb_t   strb
);
  import dpsk_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHIPS - 1);

  logic [1:0] bitCnt;
  logic [1:0] bitsNeeded;
  logic       symFull;
  logic       active;
  logic       atBoundary;

  always_comb begin
    bitsNeeded    = modeQuad ? 2'd2 : 2'd1;
    symFull       = bitCnt >= bitsNeeded;
    bitReady      = !symFull;
    atBoundary    = chipIdx == '0;
    strb.shiftIn  = bitValid && !symFull;
    strb.loadSym  = chipEn && atBoundary && symFull;
    strb.zeroOut  = chipEn && atBoundary && !symFull;
    strb.underrun = chipEn && atBoundary && !symFull && active;
    strb.emitChip = chipEn && (!atBoundary || symFull);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      chipIdx <= '0;
      active  <= 1'b0;
    end else begin
      if (strb.loadSym)      bitCnt <= '0;
      else if (strb.shiftIn) bitCnt <= bitCnt + 2'd1;

      if (strb.emitChip) chipIdx <= (chipIdx == LAST_IDX) ? '0 : chipIdx + 1'b1;

      if (strb.loadSym)       active <= 1'b1;
      else if (strb.underrun) active <= 1'b0;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    chipIdx <= LAST_IDX); // R8
  AST_LOAD_STARTS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSym |=> chipIdx == IDX_W'(1)); // R8
  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSym |=> bitReady); // R2
  AST_STOP_AFTER_UNDERRUN: assert property (@(posedge clk) disable iff (!rstN)
    strb.underrun |=> !active); // R9

endmodule

// File: rtl/dpsk_spread_dp.sv
module dpsk_spread_dp #(
  parameter int CHIPS = 11,
  parameter logic [CHIPS-1:0] BARKER = 11'b000_1110_1101,
  localparam int IDX_W = $clog2(CHIPS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modeQuad,
  input  logic                  rotReverse,
  input  logic                  bitData,
  input  logic [IDX_W-1:0]      chipIdx,
  input  dpsk_pkg::spreadStrb_t strb,
  output logic                  chipI,
  output logic                  chipQ,
  output logic                  underrun,
  output logic [1:0]            phaseRef
);
  import dpsk_pkg::*;

  logic [1:0] pendBits;
  logic [1:0] phase;
  logic [1:0] nxtPhase;
  logic       symI;
  logic       symQ;
  logic       nxtSymI;
  logic       nxtSymQ;

  dpsk_phase_step u_step (
    .curPhase  (phase),
    .modeQuad  (modeQuad),
    .rotReverse(rotReverse),
    .pendBits  (pendBits),
    .nxtPhase  (nxtPhase)
  );

  always_comb begin
    nxtSymI = nxtPhase[1];
    nxtSymQ = modeQuad ? nxtPhase[0] : nxtPhase[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendBits <= '0;
      phase    <= 2'b00;
      symI     <= 1'b0;
      symQ     <= 1'b0;
      chipI    <= 1'b0;
      chipQ    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= strb.underrun;
      if (strb.shiftIn) pendBits <= {pendBits[0], bitData};
      if (strb.loadSym) begin
        phase <= nxtPhase;
        symI  <= nxtSymI;
        symQ  <= nxtSymQ;
        chipI <= nxtSymI ^ BARKER[0];
        chipQ <= nxtSymQ ^ BARKER[0];
      end else if (strb.emitChip) begin
        chipI <= symI ^ BARKER[chipIdx];
        chipQ <= symQ ^ BARKER[chipIdx];
      end else if (strb.zeroOut) begin
        chipI <= 1'b0;
        chipQ <= 1'b0;
      end
    end
  end

  assign phaseRef = phase;

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun); // R9
  AST_ZERO_ON_GAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroOut |=> (!chipI && !chipQ)); // R9
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadSym |=> $stable(phaseRef)); // R10
  AST_BINARY_SAME: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emitChip && !modeQuad) |=> chipI == chipQ); // R3
  AST_DIBIT_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadSym && modeQuad && pendBits == 2'b00) |=> $stable(phaseRef)); // R4

endmodule

// File: rtl/dpsk_barker_spreader.sv
module dpsk_barker_spreader #(
  parameter int CHIPS = 11,
  parameter logic [CHIPS-1:0] BARKER = 11'b000_1110_1101,
  localparam int IDX_W = $clog2(CHIPS)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeQuad,
  input  logic       rotReverse,
  input  logic       chipEn,
  input  logic       bitValid,
  input  logic       bitData,
  output logic       bitReady,
  output logic       chipI,
  output logic       chipQ,
  output logic       underrun,
  output logic [1:0] phaseRef
);
  import dpsk_pkg::*;

  spreadStrb_t      strb;
  logic [IDX_W-1:0] chipIdx;

  dpsk_spread_ctrl #(.CHIPS(CHIPS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeQuad(modeQuad),
    .chipEn  (chipEn),
    .bitValid(bitValid),
    .bitReady(bitReady),
    .chipIdx (chipIdx),
    .strb    (strb)
  );

  dpsk_spread_dp #(.CHIPS(CHIPS), .BARKER(BARKER)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .modeQuad  (modeQuad),
    .rotReverse(rotReverse),
    .bitData   (bitData),
    .chipIdx   (chipIdx),
    .strb      (strb),
    .chipI     (chipI),
    .chipQ     (chipQ),
    .underrun  (underrun),
    .phaseRef  (phaseRef)
  );

endmodule

// File: tb/dpsk_barker_spreader_bench.sv
module dpsk_barker_spreader_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeQuad = 1'b0;
  logic       rotReverse = 1'b0;
  logic       chipEn = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitData = 1'b0;
  logic       bitReady;
  logic       chipI;
  logic       chipQ;
  logic       underrun;
  logic [1:0] phaseRef;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;
  logic [1:0] expPhase = 2'b00;
  int  barkerExp [11] = '{1, 0, 1, 1, 0, 1, 1, 1, 0, 0, 0};

  always #2 clk = ~clk;

  dpsk_barker_spreader u_dpsk_barker_spreader (
    .clk(clk), .rstN(rstN), .modeQuad(modeQuad), .rotReverse(rotReverse),
    .chipEn(chipEn), .bitValid(bitValid), .bitData(bitData),
    .bitReady(bitReady), .chipI(chipI), .chipQ(chipQ),
    .underrun(underrun), .phaseRef(phaseRef)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int quadDeg(input logic [1:0] q);
    case (q)
      2'b00:   return 0;
      2'b01:   return 90;
      2'b11:   return 180;
      default: return 270;
    endcase
  endfunction

  function automatic logic [1:0] degQuad(input int d);
    case (d)
      0:       return 2'b00;
      90:      return 2'b01;
      180:     return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] stepPhase(input logic [1:0] cur, input bit quad,
                                           input bit rev, input bit d0, input bit d1);
    int add;
    if (!quad) add = d0 ? 180 : 0;
    else begin
      case ({d0, d1})
        2'b00:   add = 0;
        2'b01:   add = 90;
        2'b11:   add = 180;
        default: add = 270;
      endcase
      if (rev && (add == 90 || add == 270)) add = 360 - add;
    end
    return degQuad((quadDeg(cur) + add) % 360);
  endfunction

  task automatic strobe();
    chipEn = 1'b1;
    @(negedge clk);
    chipEn = 1'b0;
  endtask

  task automatic sendBit(input bit b);
    check(bitReady == 1'b1, "R2", "ready before bit", int'(bitReady), 1);
    bitValid = 1'b1;
    bitData  = b;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic feed(input bit quad, input bit d0, input bit d1);
    sendBit(d0);
    if (quad) begin
      check(bitReady == 1'b1, "R2", "ready after first of pair", int'(bitReady), 1);
      sendBit(d1);
    end
    check(bitReady == 1'b0, "R2", "ready low when symbol full", int'(bitReady), 0);
  endtask

  task automatic runSymbols(input bit quad, input bit rev, input int nSym, input bit directed);
    bit d0, d1;
    bit eI, eQ;
    int v;
    modeQuad   = quad;
    rotReverse = rev;
    v = directed ? 0 : int'($urandom % 4);
    d0 = v[1]; d1 = v[0];
    feed(quad, d0, d1);
    for (int s = 0; s < nSym; s++) begin
      strobe();
      expPhase = stepPhase(expPhase, quad, rev, d0, d1);
      eI = expPhase[1];
      eQ = quad ? expPhase[0] : expPhase[1];
      check(phaseRef == expPhase, quad ? (rev ? "R5" : "R4") : "R3", "phase after load",
            int'(phaseRef), int'(expPhase));
      check(chipI == (eI ^ barkerExp[0][0]), "R8", "first chip I", int'(chipI), int'(eI ^ barkerExp[0][0]));
      check(chipQ == (eQ ^ barkerExp[0][0]), quad ? "R6" : "R3", "first chip Q",
            int'(chipQ), int'(eQ ^ barkerExp[0][0]));
      check(bitReady == 1'b1, "R2", "ready after load", int'(bitReady), 1);
      if (s < nSym - 1) begin
        v = directed ? ((s + 1) % 4) : int'($urandom % 4);
        d0 = v[1]; d1 = v[0];
        feed(quad, d0, d1);
      end
      for (int n = 1; n < 11; n++) begin
        strobe();
        check(chipI == (eI ^ barkerExp[n][0]), "R7", "chip I", int'(chipI), int'(eI ^ barkerExp[n][0]));
        check(chipQ == (eQ ^ barkerExp[n][0]), quad ? "R6" : "R3", "chip Q",
              int'(chipQ), int'(eQ ^ barkerExp[n][0]));
        if (n == 5) begin
          @(negedge clk);
          check(chipI == (eI ^ barkerExp[n][0]), "R7", "hold between strobes",
                int'(chipI), int'(eI ^ barkerExp[n][0]));
        end
      end
    end
    strobe();
    check(chipI == 1'b0 && chipQ == 1'b0, "R9", "zero chips on gap", int'({chipI, chipQ}), 0);
    check(underrun == 1'b1, "R9", "underrun raised", int'(underrun), 1);
    check(phaseRef == expPhase, "R10", "phase held on underrun", int'(phaseRef), int'(expPhase));
    @(negedge clk);
    check(underrun == 1'b0, "R9", "underrun one cycle", int'(underrun), 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung, expected completion");
      finish();
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(phaseRef == 2'b00, "R1", "reset phase", int'(phaseRef), 0);
    check(chipI == 1'b0 && chipQ == 1'b0, "R1", "reset chips", int'({chipI, chipQ}), 0);
    check(underrun == 1'b0, "R1", "reset underrun", int'(underrun), 0);
    check(bitReady == 1'b1, "R1", "reset ready", int'(bitReady), 1);

    strobe();
    check(chipI == 1'b0 && chipQ == 1'b0, "R9", "idle strobe zero chips", int'({chipI, chipQ}), 0);
    check(underrun == 1'b0, "R9", "idle strobe no underrun", int'(underrun), 0);
    @(negedge clk);

    runSymbols(1'b1, 1'b0, 8, 1'b1);
    runSymbols(1'b1, 1'b1, 8, 1'b1);
    runSymbols(1'b0, 1'b0, 6, 1'b1);
    check(phaseRef == expPhase, "R10", "phase kept across mode change", int'(phaseRef), int'(expPhase));
    for (int k = 0; k < 8; k++) begin
      runSymbols(1'(($urandom % 2)), 1'(($urandom % 2)), 3 + int'($urandom % 5), 1'b0);
    end
    finish();
  end

endmodule